// File: doc/BRIEF.md
# I2C Register Slave with Read-Latency Stretching

This block is the two-wire serial control port of a chip whose register space is split in two. The lower part, sub-addresses 00h to 3Fh, is a local register file served in the same cycle. The upper part, 40h and above, belongs to a slow internal processor. The block reaches it through a single-outstanding request/valid fetch port whose answer may take many cycles.

Both bus lines are oversampled by the system clock through a two-flop synchronizer and a glitch filter. A strap input chooses one of two device addresses, so two chips can share one bus. A sub-address pointer selects the register, and every data byte advances it. For an upper-space read the block normally holds SCL low before each data byte until the processor answers. A control bit turns this off in favour of a two-read scheme: the first read returns stale data and starts a background fetch, and the second read of the same register returns the fetched value.

A software reset written over the bus clears the fetch side and keeps the register contents. The active-low reset input clears everything, including the registers.

Top module: `i2c_regslave`

## Requirements
- R1: The 7-bit device address is 40h when `addr_sel` is 0 and 50h when it is 1, giving write/read bytes 80h/81h or A0h/A1h. A matching address byte is acknowledged (SDA low in the ninth clock).
- R2: A non-matching address byte is not acknowledged. The block then drives neither line until the next START or STOP.
- R3: In a write, the byte after the address is the sub-address and every further byte is acknowledged. Data for 00h–0Fh is stored. Data for any other sub-address is acknowledged and dropped, and reads of 10h–3Fh return 00h.
- R4: The pointer advances by one after every data byte, written or read, and keeps its value across STOP. A read that does not set the pointer continues where the last transfer left off.
- R5: Read data goes out MSB first. A master ACK makes the block send the next byte. A master NACK ends the read, and SDA is released.
- R6: With stretching on (control register 00h bit 1 = 0), an upper-space read issues before each data byte one `fetch_req` pulse with `fetch_addr` equal to the pointer. It then holds SCL low until `fetch_vld` and sends `fetch_data`.
- R7: A pulse on SDA or SCL shorter than the filter length is ignored. A short low glitch on SDA while SCL is high therefore neither aborts nor corrupts a transfer.
- R8: With 00h bit 1 = 1, SCL is never held. An upper-space read returns the latched fetch result if its sub-address equals the pointer, else 00h. If no fetch is outstanding, the read also starts a fetch for the pointer, and its result is latched.
- R9: Writing 1 to 00h bit 0 pulses `core_srst` for one cycle and clears the fetch latch and any outstanding fetch. The bit reads back 0 and the register contents are kept. If `fetch_vld` arrives in the cycle of the pulse, the soft reset wins and nothing is latched.
- R10: While `rst_n` is low, all registers return to 00h, the bus logic goes idle and `scl_oe`, `sda_oe`, `fetch_req` and `core_srst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low hardware reset |
| addr_sel | input | 1 | Strap selecting the device address |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| fetch_req | output | 1 | One-cycle request to the internal processor |
| fetch_addr | output | 8 | Sub-address of the request, held until answered |
| fetch_vld | input | 1 | Response strobe from the processor |
| fetch_data | input | 8 | Response data, valid with `fetch_vld` |
| core_srst | output | 1 | One-cycle software reset pulse to the chip core |

## Verification
The two functions that can land in one clock edge are the software-reset pulse and a fetch response returning in stretch-off mode. Both write the fetch latch, one clearing it and one filling it. The bench leaves a dummy read's fetch unanswered, writes the soft-reset bit, and has the responder raise `fetch_vld` at the negative edge where `core_srst` is seen high, so that both reach the same rising edge. A second read of that register must then return 00h rather than the fetched value, which shows the reset took priority.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_SUB,
        S_SUB_ACK,
        S_WR,
        S_WR_ACK,
        S_FETCH,
        S_TX,
        S_TX_ACK
    } eng_state_e;

endpackage

// File: rtl/i2c_regslave_filt.sv
module i2c_regslave_filt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_flt
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          flt;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], pin_raw};
        if (q.sync[1] == q.flt) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_LEN - 1)) begin
            d.flt = q.sync[1];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.flt  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pin_flt = q.flt;

    // R7
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flt != $past(q.flt)) |-> ($past(q.sync[1]) == q.flt));

endmodule

// File: rtl/i2c_regslave_regs.sv
module i2c_regslave_regs #(
    parameter int NREG = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       stretch_off,
    output logic       srst
);
    localparam int IW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][7:0] mem;
        logic                 srst;
    } regs_t;

    regs_t d, q;

    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (wr_en && (wr_addr < 8'(NREG))) begin
            if (wr_addr == 8'h00) begin
                d.mem[0] = wr_data & 8'hFE;
                d.srst   = wr_data[0];
            end else begin
                d.mem[wr_addr[IW-1:0]] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data     = (rd_addr < 8'(NREG)) ? q.mem[rd_addr[IW-1:0]] : 8'h00;
    assign stretch_off = q.mem[0][1];
    assign srst        = q.srst;

    // R9
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !srst);

endmodule

// File: rtl/i2c_regslave_engine.sv
module i2c_regslave_engine
    import i2c_regslave_pkg::*;
#(
    parameter logic [7:0] HI_BASE = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] dev_addr,
    input  logic       stretch_off,
    input  logic       srst,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       fetch_req,
    output logic [7:0] fetch_addr,
    input  logic       fetch_vld,
    input  logic [7:0] fetch_data,
    output logic       scl_oe,
    output logic       sda_oe
);
    typedef struct packed {
        eng_state_e        st;
        logic [3:0]        bits;
        logic [BYTE_W-1:0] sh;
        logic [7:0]        ptr;
        logic              rnw;
        logic              mack;
        logic              sda_oe;
        logic              scl_oe;
        logic              req;
        logic [7:0]        raddr;
        logic              pend;
        logic              lvld;
        logic [7:0]        laddr;
        logic [7:0]        ldata;
        logic              scl_p;
        logic              sda_p;
        logic              wr_en;
        logic [7:0]        waddr;
    } eng_t;

    eng_t d, q;
    logic start_c, stop_c, rise_c, fall_c;

    function automatic eng_t load_byte(eng_t s);
        eng_t r = s;
        r.bits = '0;
        if (s.ptr >= HI_BASE) begin
            if (!stretch_off) begin
                r.st     = S_FETCH;
                r.scl_oe = 1'b1;
                r.req    = 1'b1;
                r.raddr  = s.ptr;
            end else begin
                r.sh = (s.lvld && (s.laddr == s.ptr)) ? s.ldata : 8'h00;
                if (!s.pend) begin
                    r.req   = 1'b1;
                    r.raddr = s.ptr;
                    r.pend  = 1'b1;
                end
                r.st     = S_TX;
                r.sda_oe = ~r.sh[7];
            end
        end else begin
            r.sh     = rd_data;
            r.sda_oe = ~rd_data[7];
            r.st     = S_TX;
        end
        return r;
    endfunction

    assign start_c = q.scl_p &  scl_f &  q.sda_p & ~sda_f;
    assign stop_c  = q.scl_p &  scl_f & ~q.sda_p &  sda_f;
    assign rise_c  = ~q.scl_p &  scl_f;
    assign fall_c  =  q.scl_p & ~scl_f;

    always_comb begin
        d       = q;
        d.req   = 1'b0;
        d.wr_en = 1'b0;
        d.scl_p = scl_f;
        d.sda_p = sda_f;

        // background fetch result (stretch-off mode)
        if (fetch_vld && q.pend) begin
            d.pend  = 1'b0;
            d.lvld  = 1'b1;
            d.laddr = q.raddr;
            d.ldata = fetch_data;
        end
        if (srst) begin
            d.pend = 1'b0;
            d.lvld = 1'b0;
        end

        if (q.st != S_FETCH && start_c) begin
            d.st     = S_ADDR;
            d.bits   = '0;
            d.sda_oe = 1'b0;
        end else if (q.st != S_FETCH && stop_c) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            case (q.st)
                S_ADDR, S_SUB, S_WR: begin
                    if (rise_c) begin
                        d.sh   = {q.sh[6:0], sda_f};
                        d.bits = q.bits + 4'd1;
                    end else if (fall_c && q.bits == 4'd8) begin
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:1] == dev_addr) begin
                                d.sda_oe = 1'b1;
                                d.rnw    = q.sh[0];
                                d.st     = S_ADDR_ACK;
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else if (q.st == S_SUB) begin
                            d.ptr    = q.sh;
                            d.sda_oe = 1'b1;
                            d.st     = S_SUB_ACK;
                        end else begin
                            d.wr_en  = 1'b1;
                            d.waddr  = q.ptr;
                            d.ptr    = q.ptr + 8'd1;
                            d.sda_oe = 1'b1;
                            d.st     = S_WR_ACK;
                        end
                    end
                end
                S_ADDR_ACK: begin
                    if (fall_c) begin
                        d.sda_oe = 1'b0;
                        if (q.rnw) begin
                            d = load_byte(d);
                        end else begin
                            d.st   = S_SUB;
                            d.bits = '0;
                        end
                    end
                end
                S_SUB_ACK, S_WR_ACK: begin
                    if (fall_c) begin
                        d.sda_oe = 1'b0;
                        d.st     = S_WR;
                        d.bits   = '0;
                    end
                end
                S_FETCH: begin
                    if (fetch_vld) begin
                        d.sh     = fetch_data;
                        d.sda_oe = ~fetch_data[7];
                        d.scl_oe = 1'b0;
                        d.st     = S_TX;
                        d.bits   = '0;
                    end
                end
                S_TX: begin
                    if (fall_c) begin
                        if (q.bits == 4'd7) begin
                            d.sda_oe = 1'b0;
                            d.ptr    = q.ptr + 8'd1;
                            d.st     = S_TX_ACK;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.sda_oe = ~q.sh[6];
                            d.bits   = q.bits + 4'd1;
                        end
                    end
                end
                S_TX_ACK: begin
                    if (rise_c) begin
                        d.mack = ~sda_f;
                    end else if (fall_c) begin
                        if (q.mack) begin
                            d = load_byte(d);
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr    = q.ptr;
    assign wr_en      = q.wr_en;
    assign wr_addr    = q.waddr;
    assign wr_data    = q.sh;
    assign fetch_req  = q.req;
    assign fetch_addr = q.raddr;
    assign scl_oe     = q.scl_oe;
    assign sda_oe     = q.sda_oe;

    // R6
    stretch_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> fetch_req);

    // R6
    release_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(fetch_vld));

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req);

    // R8
    no_stretch_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_off && !scl_oe) |=> !scl_oe);

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
    parameter int         FILT_LEN = 4,
    parameter int         NREG     = 16,
    parameter logic [7:0] HI_BASE  = 8'h40,
    parameter logic [6:0] DEV_LO   = 7'h40,
    parameter logic [6:0] DEV_HI   = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       fetch_req,
    output logic [7:0] fetch_addr,
    input  logic       fetch_vld,
    input  logic [7:0] fetch_data,
    output logic       core_srst
);
    logic [1:0] raw, flt;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_en, stretch_off, srst;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_regslave_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (raw[g]),
            .pin_flt (flt[g])
        );
    end

    i2c_regslave_regs #(.NREG(NREG)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .stretch_off (stretch_off),
        .srst        (srst)
    );

    i2c_regslave_engine #(.HI_BASE(HI_BASE)) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_f       (flt[1]),
        .sda_f       (flt[0]),
        .dev_addr    (addr_sel ? DEV_HI : DEV_LO),
        .stretch_off (stretch_off),
        .srst        (srst),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_vld   (fetch_vld),
        .fetch_data  (fetch_data),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    assign core_srst = srst;

endmodule

// File: tb/test_i2c_regslave.sv
`timescale 1ns/1ps
module test_i2c_regslave;

    localparam int H   = 24;
    localparam int LAT = 150;
    localparam int NV  = 9;
    // {write, sub, data, expected}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h02, 8'hA5, 8'h01},
        {1'b1, 8'h0F, 8'h3C, 8'h01},
        {1'b1, 8'h25, 8'h77, 8'h01},
        {1'b0, 8'h02, 8'h00, 8'hA5},
        {1'b0, 8'h0F, 8'h00, 8'h3C},
        {1'b0, 8'h25, 8'h00, 8'h00},
        {1'b0, 8'h20, 8'h00, 8'h00},
        {1'b0, 8'h41, 8'h00, 8'h1B},
        {1'b0, 8'h7F, 8'h00, 8'h25}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic addr_sel = 0;
    logic scl_m = 1, sda_m = 1;
    logic scl, sda;
    logic scl_oe, sda_oe, fetch_req, fetch_vld, core_srst;
    logic [7:0] fetch_addr, fetch_data, resp_addr;
    logic collide = 0, glitch_arm = 0;
    logic [7:0] dev8 = 8'h80;
    int checks = 0, errors = 0;
    int n_req = 0, n_hold = 0, n_srst = 0;

    always #5 clk = ~clk;

    assign scl = scl_m & ~scl_oe;
    assign sda = sda_m & ~sda_oe;

    i2c_regslave i_i2c_regslave (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
        .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_vld(fetch_vld), .fetch_data(fetch_data), .core_srst(core_srst)
    );

    always @(negedge clk) begin
        if (fetch_req) n_req++;
        if (scl_oe) n_hold++;
        if (core_srst) n_srst++;
    end

    // processor model: fixed latency, or answer in the soft-reset cycle
    initial begin
        fetch_vld = 0;
        fetch_data = 0;
        forever begin
            @(negedge clk);
            if (fetch_req) begin
                resp_addr = fetch_addr;
                if (collide) begin
                    while (core_srst !== 1'b1) @(negedge clk);
                end else begin
                    repeat (LAT) @(negedge clk);
                end
                fetch_vld = 1;
                fetch_data = resp_addr ^ 8'h5A;
                @(negedge clk);
                fetch_vld = 0;
            end
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_scl_high();
        while (scl !== 1'b1) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_m = b;
        wcyc(H);
        scl_m = 1;
        wait_scl_high();
        wcyc(4);
        if (glitch_arm && b) begin
            sda_m = 0;
            wcyc(2);
            sda_m = 1;
            glitch_arm = 0;
        end
        wcyc(H / 2 - 4);
        s = sda;
        wcyc(H / 2);
        scl_m = 0;
        wcyc(H / 2);
    endtask

    task automatic bus_start();
        sda_m = 1;
        wcyc(H / 2);
        scl_m = 1;
        wait_scl_high();
        wcyc(H);
        sda_m = 0;
        wcyc(H);
        scl_m = 0;
        wcyc(H / 2);
    endtask

    task automatic bus_stop();
        sda_m = 0;
        wcyc(H / 2);
        scl_m = 1;
        wait_scl_high();
        wcyc(H);
        sda_m = 1;
        wcyc(H);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            b[i] = s;
        end
        bit_xfer(last, s);
    endtask

    task automatic do_write(input logic [7:0] sub, input logic [7:0] d0, d1, d2,
                            input int n, output logic ok);
        logic a;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        wr_byte(dev8, a); ok = a;
        wr_byte(sub, a); ok = ok & a;
        for (int i = 0; i < n; i++) begin
            wr_byte(dv[i], a);
            ok = ok & a;
        end
        bus_stop();
    endtask

    task automatic raw_read(input int n, output logic [7:0] r0, r1, r2);
        logic a;
        logic [7:0] rv [3];
        rv[0] = 0; rv[1] = 0; rv[2] = 0;
        bus_start();
        wr_byte(dev8 | 8'h01, a);
        for (int i = 0; i < n; i++) rd_byte(i == n - 1, rv[i]);
        bus_stop();
        r0 = rv[0]; r1 = rv[1]; r2 = rv[2];
    endtask

    task automatic do_read(input logic [7:0] sub, input int n, output logic [7:0] r0, r1, r2);
        logic ok;
        do_write(sub, 0, 0, 0, 0, ok);
        raw_read(n, r0, r1, r2);
    endtask

    initial begin
        logic ok, a;
        logic [7:0] r0, r1, r2;
        int snap, snap2;

        wcyc(5);
        // R10 reset state of the outputs
        check("R10 outputs in reset", {4'h0, scl_oe, sda_oe, fetch_req, core_srst}, 8'h00);
        rst_n = 1;
        wcyc(20);

        // vector table: R1 and R3 writes, R3 and R6 reads
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][24]) begin
                do_write(VEC[v][23:16], VEC[v][15:8], 0, 0, 1, ok);
                check("R1 R3 write acknowledged", {7'h0, ok}, VEC[v][7:0]);
            end else begin
                do_read(VEC[v][23:16], 1, r0, r1, r2);
                check(VEC[v][23:16] >= 8'h40 ? "R6 high read" : "R3 local read", r0, VEC[v][7:0]);
            end
        end

        // R4 auto-increment on write and read, pointer kept across STOP
        do_write(8'h05, 8'h11, 8'h22, 8'h33, 3, ok);
        check("R4 burst write ack", {7'h0, ok}, 8'h01);
        do_read(8'h05, 2, r0, r1, r2);
        check("R4 R5 burst read byte0", r0, 8'h11);
        check("R4 R5 burst read byte1", r1, 8'h22);
        raw_read(1, r0, r1, r2);
        check("R4 pointer kept across STOP", r0, 8'h33);
        check("R5 SDA released after NACK", {7'h0, sda_oe}, 8'h00);

        // R6 two-byte high read, each byte stretched
        snap = n_req;
        snap2 = n_hold;
        do_read(8'h50, 2, r0, r1, r2);
        check("R6 stretched byte0", r0, 8'h0A);
        check("R6 stretched byte1", r1, 8'h0B);
        check("R6 one request per byte", 8'(n_req - snap), 8'h02);
        check("R6 SCL held for fetch", {7'h0, (n_hold - snap2) >= 2 * LAT}, 8'h01);

        // R1 strap high: A0h/A1h
        addr_sel = 1;
        do_write(8'h03, 8'h5E, 0, 0, 1, ok);
        check("R2 80h refused with strap high", {7'h0, ok}, 8'h00);
        dev8 = 8'hA0;
        do_write(8'h03, 8'h5E, 0, 0, 1, ok);
        check("R1 A0h accepted", {7'h0, ok}, 8'h01);
        do_read(8'h03, 1, r0, r1, r2);
        check("R1 read via A1h", r0, 8'h5E);
        addr_sel = 0;
        dev8 = 8'h80;

        // R2 mismatch is NACKed and bus ignored until STOP
        bus_start();
        wr_byte(8'hA0, a);
        check("R2 mismatch NACK", {7'h0, a}, 8'h00);
        wr_byte(8'h00, a);
        check("R2 no ack while ignoring", {7'h0, a}, 8'h00);
        bus_stop();
        do_read(8'h03, 1, r0, r1, r2);
        check("R2 register untouched", r0, 8'h5E);

        // R7 short SDA glitch while SCL high
        glitch_arm = 1;
        do_write(8'h09, 8'hC3, 0, 0, 1, ok);
        check("R7 glitched write ack", {7'h0, ok}, 8'h01);
        do_read(8'h09, 1, r0, r1, r2);
        check("R7 glitched write data", r0, 8'hC3);

        // R8 stretch off: dummy read, then valid read
        do_write(8'h00, 8'h02, 0, 0, 1, ok);
        snap2 = n_hold;
        do_read(8'h48, 1, r0, r1, r2);
        wcyc(2 * LAT);
        do_read(8'h48, 1, r0, r1, r2);
        check("R8 second read valid", r0, 8'h12);
        do_read(8'h49, 1, r0, r1, r2);
        check("R8 unmatched read gives 00h", r0, 8'h00);
        check("R8 no SCL hold", 8'(n_hold - snap2), 8'h00);
        wcyc(2 * LAT);

        // R9 soft reset
        snap = n_srst;
        do_write(8'h00, 8'h03, 0, 0, 1, ok);
        check("R9 one srst pulse", 8'(n_srst - snap), 8'h01);
        do_read(8'h00, 1, r0, r1, r2);
        check("R9 control bit self-clears", r0, 8'h02);
        do_read(8'h02, 1, r0, r1, r2);
        check("R9 registers kept", r0, 8'hA5);
        do_read(8'h49, 1, r0, r1, r2);
        check("R9 latch cleared", r0, 8'h00);
        wcyc(2 * LAT);

        // R9 soft reset and fetch response in the same cycle
        collide = 1;
        do_read(8'h4A, 1, r0, r1, r2);
        do_write(8'h00, 8'h03, 0, 0, 1, ok);
        wcyc(4);
        collide = 0;
        do_read(8'h4A, 1, r0, r1, r2);
        check("R9 srst wins over response", r0, 8'h00);
        wcyc(2 * LAT);

        // R10 hardware reset restores defaults
        rst_n = 0;
        wcyc(5);
        check("R10 outputs in reset", {4'h0, scl_oe, sda_oe, fetch_req, core_srst}, 8'h00);
        rst_n = 1;
        wcyc(20);
        do_read(8'h02, 1, r0, r1, r2);
        check("R10 register default", r0, 8'h00);
        do_read(8'h00, 1, r0, r1, r2);
        check("R10 control default", r0, 8'h00);
        snap2 = n_hold;
        do_read(8'h41, 1, r0, r1, r2);
        check("R10 stretching back on", r0, 8'h1B);
        check("R10 SCL held after reset", {7'h0, (n_hold - snap2) > 0}, 8'h01);

        finish_sim();
    end

endmodule